// File: doc/BRIEF.md
# Cascadable Dual Event Counter

The block counts rising edges on an external event line, sampled in the system clock domain. It holds two counter halves, each `HALF_W` bits wide (8 by default). A mode bit either chains the halves into one counter of twice the width, with the low half carrying into the high half, or lets each half count the same event stream on its own. Each half has its own count-enable bit and its own run bit. A cleared run bit forces that half to zero. Each half also has a sticky wrap flag.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads are combinational and are selected by the same address. There are four registers:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | mode bit, enable bits, run bits, wrap flags |
| 1 | Power | run/standby bit |
| 2 | Low count | low half, read-only |
| 3 | High count | high half, read-only |

A cleared power bit puts the block in standby. In standby, events are dropped and both counts and both flags are frozen. Software start-up sequence:
1. Select the mode.
2. Clear the enable bits and run bits.
3. Clear the flags.
4. Set the enable bits and run bits together.

Top module: `evt_cnt_pair`

## Requirements
- R1: After reset, every register bit reads as follows:
  - The control register (address 0) reads 0x00. This means chained mode (bit0 = 0), both enables off, both run bits off and both flags clear.
  - The power register (address 1) reads 0x01 (running).
  - Both counts (addresses 2 and 3) read 0.
- R2: `evt_in` passes through a two-stage synchroniser and then a rising-edge detector. Each low-to-high transition adds exactly one count, however long the line stays high. A count appears three clock edges after the line rises.
- R3: While a half's run bit is 0, that half reads 0 and does not count. The low run bit is control bit3; the high run bit is control bit4.
- R4: While a half's enable bit is 0 and its run bit is 1, that half keeps its value. The low enable is control bit1; the high enable is control bit2.
- R5: In chained mode (control bit0 = 0), the high half increments only on an event that wraps the low half from all-ones to zero. Both halves update on the same clock edge.
- R6: In chained mode, one event at all-ones in both halves wraps the whole counter to zero, and counting then continues from zero. That event sets the high flag (control bit6). The low flag (control bit5) is never set in this mode.
- R7: In split mode (control bit0 = 1), each enabled and running half counts every event independently. A wrap of the low half sets bit5; a wrap of the high half sets bit6.
- R8: The flags are sticky. Writing control with a flag bit at 0 clears that flag; writing it at 1 leaves the flag unchanged. A wrap on the same edge as a clearing write leaves the flag set.
- R9: While the power bit (address 1, bit0) is 0:
  - events are ignored;
  - both counts and both flags hold, and flag-clearing writes have no effect;
  - writes to the mode, enable, run and power bits still take effect.
- R10: Writes to addresses 2 and 3 are ignored. Unused read bits return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 1 | Asynchronous event line |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data at `addr` |

## Verification
A wrong carry decision or a missed wrap shows up in the count readback on the event's own update edge, three clocks after the line rises. This is because the bench reads the counts after every event of full-range sweeps in both modes, at a reduced half width. A flag that is set, cleared or held wrongly shows in the control readback at the next read. The bench aligns the set-against-clear race to that exact edge. Errors in standby and gating leave the counts or flags changed, or unchanged, after a burst of events, and the readback taken right after the burst catches this.

// File: rtl/evt_cnt_pkg.sv
// Shared constants for the dual event counter: register addresses and
// field positions. Assumes an 8-bit register data path.
package evt_cnt_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_PWR    = 2'd1,
        REG_CNT_LO = 2'd2,
        REG_CNT_HI = 2'd3
    } reg_sel_e;

    // control register field positions
    localparam int B_SPLIT  = 0;
    localparam int B_EN_LO  = 1;
    localparam int B_EN_HI  = 2;
    localparam int B_RUN_LO = 3;
    localparam int B_RUN_HI = 4;
    localparam int B_OVF_LO = 5;
    localparam int B_OVF_HI = 6;
    // power register field position
    localparam int B_ACTIVE = 0;
endpackage

// File: rtl/evt_edge_sync.sv
// Brings an asynchronous event line into the clock domain through a chain
// of STAGES flops and flags each rising transition for one cycle.
// Assumes the event line stays at each level for at least two clocks.
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    // shift the raw line through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], evt_in};
    end

    // remember the last synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;

    // R2: one transition gives one pulse, never two back to back
    p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/evt_half_cnt.sv
// One counter half. It is cleared while its run bit is low, counts an increment
// request while enabled, and reports a wrap from all-ones to zero. A freeze
// input holds the value unconditionally (standby).
module evt_half_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frz,
    input  logic         run,
    input  logic         en,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic step;
    assign step = !frz && run && en && inc;
    assign wrap = step && (cnt == ALL_ONES);

    // count register: freeze, then clear by run bit, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (frz)  cnt <= cnt;
        else if (!run) cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end

    // R3: a low run bit outside standby forces zero
    p_run_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz && !run) |=> (cnt == '0));
    // R4: a disabled running half keeps its value
    p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && run) |=> $stable(cnt));
endmodule

// File: rtl/evt_cnt_regs.sv
// Register file of the dual event counter: mode, enables, run bits, power bit
// and the two sticky wrap flags, plus the combinational read mux. Flags are
// cleared by writing 0, set by wrap pulses; set wins; all frozen in standby.
module evt_cnt_regs
    import evt_cnt_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_lo,
    input  logic              set_hi,
    input  logic [HALF_W-1:0] cnt_lo,
    input  logic [HALF_W-1:0] cnt_hi,
    output logic              split,
    output logic              en_lo,
    output logic              en_hi,
    output logic              run_lo,
    output logic              run_hi,
    output logic              active,
    output logic              ovf_lo,
    output logic              ovf_hi,
    output logic [DATA_W-1:0] rd_data
);
    reg_sel_e sel;
    logic     ctrl_wr;
    logic     clr_lo;
    logic     clr_hi;
    logic     unused_wr;

    assign sel       = reg_sel_e'(addr);
    assign ctrl_wr   = wr_en && (sel == REG_CTRL);
    assign clr_lo    = ctrl_wr && !wr_data[B_OVF_LO];
    assign clr_hi    = ctrl_wr && !wr_data[B_OVF_HI];
    assign unused_wr = ^{wr_data[DATA_W-1], wr_data[DATA_W-2:B_OVF_HI+1]};

    // control and power fields, written regardless of standby
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split  <= 1'b0;
            en_lo  <= 1'b0;
            en_hi  <= 1'b0;
            run_lo <= 1'b0;
            run_hi <= 1'b0;
            active <= 1'b1;
        end else if (wr_en) begin
            case (sel)
                REG_CTRL: begin
                    split  <= wr_data[B_SPLIT];
                    en_lo  <= wr_data[B_EN_LO];
                    en_hi  <= wr_data[B_EN_HI];
                    run_lo <= wr_data[B_RUN_LO];
                    run_hi <= wr_data[B_RUN_HI];
                end
                REG_PWR: active <= wr_data[B_ACTIVE];
                default: ;
            endcase
        end
    end

    // sticky wrap flags, set has priority, frozen while in standby
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_lo <= 1'b0;
            ovf_hi <= 1'b0;
        end else if (active) begin
            ovf_lo <= set_lo | (ovf_lo & ~clr_lo);
            ovf_hi <= set_hi | (ovf_hi & ~clr_hi);
        end
    end

    // read mux, unused bits zero
    always_comb begin
        rd_data = '0;
        case (sel)
            REG_CTRL: begin
                rd_data[B_SPLIT]  = split;
                rd_data[B_EN_LO]  = en_lo;
                rd_data[B_EN_HI]  = en_hi;
                rd_data[B_RUN_LO] = run_lo;
                rd_data[B_RUN_HI] = run_hi;
                rd_data[B_OVF_LO] = ovf_lo;
                rd_data[B_OVF_HI] = ovf_hi;
            end
            REG_PWR:    rd_data[B_ACTIVE] = active;
            REG_CNT_LO: rd_data[HALF_W-1:0] = cnt_lo;
            REG_CNT_HI: rd_data[HALF_W-1:0] = cnt_hi;
            default:    rd_data = '0;
        endcase
    end

    // R8: a flag stays set unless a clearing write arrives
    p_sticky_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_lo && !clr_lo) |=> ovf_lo);
    p_sticky_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hi && !clr_hi) |=> ovf_hi);
    // R8: a wrap wins over a same-edge clear
    p_set_wins_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_lo |=> ovf_lo);
    p_set_wins_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_hi |=> ovf_hi);
endmodule

// File: rtl/evt_cnt_pair.sv
// Top of the dual event counter. Synchronises the event line, steers the
// increment into the two halves (chained or split) and feeds wrap pulses to
// the register file. Assumes HALF_W <= 8 so a count fits one register.
module evt_cnt_pair
    import evt_cnt_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic              rise;
    logic              split, en_lo, en_hi, run_lo, run_hi, active;
    logic              ovf_lo, ovf_hi;
    logic              frz;
    logic              inc_hi;
    logic              wrap_lo, wrap_hi;
    logic              set_lo, set_hi;
    logic [HALF_W-1:0] cnt_lo, cnt_hi;

    evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .rise(rise)
    );

    assign frz    = !active;
    // chained: high half steps on low wrap; split: it sees every event
    assign inc_hi = split ? rise : wrap_lo;
    assign set_lo = split && wrap_lo;
    assign set_hi = wrap_hi;

    evt_half_cnt #(.W(HALF_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .frz(frz), .run(run_lo), .en(en_lo),
        .inc(rise), .cnt(cnt_lo), .wrap(wrap_lo)
    );

    evt_half_cnt #(.W(HALF_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .frz(frz), .run(run_hi), .en(en_hi),
        .inc(inc_hi), .cnt(cnt_hi), .wrap(wrap_hi)
    );

    evt_cnt_regs #(.HALF_W(HALF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .set_lo(set_lo), .set_hi(set_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .split(split), .en_lo(en_lo),
        .en_hi(en_hi), .run_lo(run_lo), .run_hi(run_hi), .active(active),
        .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .rd_data(rd_data)
    );

    // R5: chained high half moves only with a low wrap
    p_carry_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && run_hi && !wrap_lo) |=> $stable(cnt_hi));
    // R6: chained mode never raises the low flag
    p_lo_flag_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && !ovf_lo) |=> !ovf_lo);
    // R9: standby freezes counts and flags
    p_standby_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(cnt_lo) && $stable(cnt_hi)
                     && $stable(ovf_lo) && $stable(ovf_hi)));
endmodule

// File: tb/tb_evt_cnt_pair.sv
// Self-checking bench for evt_cnt_pair at a 4-bit half width, sweeping the
// full counter range in both modes with arithmetically computed expectations.
module tb_evt_cnt_pair;
    localparam int CLK_PERIOD = 10;
    localparam int HW         = 4;
    localparam int HMOD       = 1 << HW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    evt_cnt_pair #(.HALF_W(HW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        addr = a;
        #1;
        d = int'(rd_data);
    endtask

    // one short event; the count has updated when the task returns
    task automatic pulse();
        @(negedge clk); evt_in = 1'b1;
        @(negedge clk); evt_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_counts(input string req, input int lo, input int hi);
        int v;
        rd(2'd2, v); check(req, v, lo);
        rd(2'd3, v); check(req, v, hi);
    endtask

    function automatic int ctrl_val(input bit sp, input bit el, input bit eh,
                                    input bit rl, input bit rh,
                                    input bit ol, input bit oh);
        return int'(sp) | (int'(el) << 1) | (int'(eh) << 2) | (int'(rl) << 3)
             | (int'(rh) << 4) | (int'(ol) << 5) | (int'(oh) << 6);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int v;
        int total;
        int lo, hi;
        bit ovl, ovh;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 power", v, 1);
        chk_counts("R1 counts", 0, 0);

        // R3: enabled but not running halves stay at zero
        wr(2'd0, 8'h06);
        repeat (3) pulse();
        chk_counts("R3 held at zero", 0, 0);

        // start counting in chained mode, flags kept (written as 1)
        wr(2'd0, 8'h7E);
        // R2: a long high level counts once
        @(negedge clk); evt_in = 1'b1;
        repeat (8) @(negedge clk);
        evt_in = 1'b0;
        repeat (3) @(negedge clk);
        chk_counts("R2 long level", 1, 0);
        // R2: update latency of three edges after the rise
        @(negedge clk); evt_in = 1'b1;
        @(negedge clk); evt_in = 1'b0;
        @(negedge clk);
        rd(2'd2, v); check("R2 not yet", v, 1);
        @(negedge clk);
        rd(2'd2, v); check("R2 after 3 edges", v, 2);

        // R5 / R6: full chained sweep with wrap
        total = 2; ovh = 1'b0;
        for (int i = 0; i < HMOD*HMOD + 3; i++) begin
            pulse();
            total = (total + 1) % (HMOD*HMOD);
            if (total == 0) ovh = 1'b1;
            chk_counts("R5 chained count", total % HMOD, total / HMOD);
            rd(2'd0, v);
            check("R6 flags", v, ctrl_val(0, 1, 1, 1, 1, 0, ovh));
        end

        // R8: writing 1 keeps the flag, writing 0 clears it
        wr(2'd0, 8'h7E);
        rd(2'd0, v); check("R8 write one keeps", v, ctrl_val(0, 1, 1, 1, 1, 0, 1));
        wr(2'd0, 8'h3E);
        rd(2'd0, v); check("R8 write zero clears", v, ctrl_val(0, 1, 1, 1, 1, 0, 0));

        // R4: low disabled -> both halves frozen in chained mode
        lo = total % HMOD; hi = total / HMOD;
        wr(2'd0, 8'h7C);
        repeat (3) pulse();
        chk_counts("R4 low disabled", lo, hi);
        // R4: high disabled, low wraps, high keeps value, no flag
        wr(2'd0, 8'h7A);
        for (int i = 0; i < HMOD - lo; i++) pulse();
        chk_counts("R4 high disabled", 0, hi);
        rd(2'd0, v); check("R4 no flag", v, ctrl_val(0, 1, 0, 1, 1, 0, 0));

        // R7: split mode, zero both then sweep
        wr(2'd0, 8'h07);
        chk_counts("R3 run low zeroes", 0, 0);
        wr(2'd0, 8'h7F);
        ovl = 1'b0; ovh = 1'b0;
        for (int i = 1; i <= HMOD + 4; i++) begin
            pulse();
            if (i % HMOD == 0) begin ovl = 1'b1; ovh = 1'b1; end
            chk_counts("R7 split count", i % HMOD, i % HMOD);
            rd(2'd0, v);
            check("R7 split flags", v, ctrl_val(1, 1, 1, 1, 1, ovl, ovh));
        end
        lo = (HMOD + 4) % HMOD; hi = lo;
        wr(2'd0, 8'h7B);
        repeat (3) pulse();
        lo = lo + 3;
        chk_counts("R7 independent halves", lo, hi);

        // R8: wrap on the same edge as a clearing write leaves the flag set
        wr(2'd0, 8'h1F);
        for (int i = lo; i < HMOD - 1; i++) pulse();
        hi = (hi + (HMOD - 1 - lo)) % HMOD;
        chk_counts("R8 setup", HMOD - 1, hi);
        @(negedge clk); evt_in = 1'b1;
        @(negedge clk); evt_in = 1'b0;
        @(negedge clk); addr = 2'd0; wr_data = 8'h1F; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        hi = (hi + 1) % HMOD;
        rd(2'd0, v); check("R8 set wins", v, ctrl_val(1, 1, 1, 1, 1, 1, 0));
        chk_counts("R8 wrap count", 0, hi);

        // R9: standby freezes counts and flags; control writes still land
        wr(2'd1, 8'h00);
        repeat (3) pulse();
        chk_counts("R9 standby counts", 0, hi);
        wr(2'd0, 8'h1D);
        rd(2'd0, v); check("R9 standby ctrl", v, ctrl_val(1, 0, 1, 1, 1, 1, 0));
        rd(2'd1, v); check("R9 power reads 0", v, 0);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h1F);
        rd(2'd0, v); check("R9 clear after wake", v, ctrl_val(1, 1, 1, 1, 1, 0, 0));
        pulse();
        hi = (hi + 1) % HMOD;
        chk_counts("R9 counting resumes", 1, hi);

        // R10: count registers are read-only, unused bits zero
        wr(2'd2, 8'hAA);
        wr(2'd3, 8'h55);
        chk_counts("R10 read-only", 1, hi);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R10 unused bits", v, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule